// File: doc/BRIEF.md
# Redundant Read-Retry Table Recovery Engine

This block rebuilds a flash device's read-retry register table from a raw copy of the device's one-time-programmable page. The page is not reliable, so every stored quantity appears several times. The engine reads the page from a local byte buffer by offset and decides each quantity by majority vote. The first quantity is the number of retry modes and the second is the number of registers per mode. After that comes each mode/register value. Each value is stored eight times as written and eight more times as its bitwise complement. Each value that survives both votes and the complement cross-check is written into a value RAM.

A controller loads the buffer, pulses `start`, and waits for `done` or `error`. The accepted values come out on a single write port in mode-major order. Fetching the page from the device is left to other logic.

Top module: `rr_table_extract`

## Requirements
- R1: The mode count is the majority of buffer bytes 0..7, the register count is the majority of bytes 8..15, and both appear on `mode_count`/`reg_count` when `done` is high.
- R2: A byte is decided by testing only the copies at positions 0..3 as candidates; a candidate is accepted when at least 5 of the 8 copies equal it, and when no candidate qualifies the run ends with `error`.
- R3: A mode count of 0 or above MAX_MODES, or a register count of 0 or above MAX_REGS, ends the run with `error` before any table write.
- R4: With S = modes x regs and entry index e = m x regs + r, copy k (0..7) of entry e is read from offset 16 + 2kS + e, and its complemented copy from 16 + (2k+1)S + e; no read goes past offset 16 + 16S - 1.
- R5: An entry is accepted only when its plain majority XOR its complement majority is 0xFF; otherwise the run ends with `error` and that entry is not written.
- R6: Accepted entries are written one per entry with `tbl_addr` = e in increasing e (mode-major) and `tbl_wdata` = the plain majority; a clean run makes exactly S writes, and its last write coincides with the first cycle of `done`.
- R7: A `start` pulse while `busy` is high is ignored and the run in progress completes unchanged.
- R8: After reset `busy`, `done`, `error`, `tbl_we` and `rd_en` are low, and `rd_en` is only high while `busy` is high.
- R9: `done` and `error` are never high together, each holds until the next accepted `start`, and that `start` clears both on the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | One-cycle pulse that begins an extraction when not busy |
| rd_en | output | 1 | Buffer read request |
| rd_addr | output | BUF_AW | Buffer byte offset; data is due one cycle after `rd_en` |
| rd_data | input | 8 | Buffer byte returned one cycle after the request |
| mode_count | output | 8 | Voted number of retry modes (0 until accepted) |
| reg_count | output | 8 | Voted number of registers per mode (0 until accepted) |
| tbl_we | output | 1 | Table write strobe |
| tbl_addr | output | IDX_W | Table entry index m x regs + r |
| tbl_wdata | output | 8 | Recovered register value |
| busy | output | 1 | Extraction in progress |
| done | output | 1 | Extraction finished cleanly |
| error | output | 1 | Extraction aborted |

## Verification
The assertions assume that the buffer returns the addressed byte exactly one cycle after each `rd_en` and that its contents stay fixed while `busy` is high. They also assume that `start` is a one-cycle pulse. The bench models the buffer as a registered read of a byte array. It loads each image only while the engine is idle, and drives `start` for one cycle on the falling edge. Under these assumptions, the write-order, read-range and count-range properties can relate the ports directly, without modelling the buffer contents.

// File: rtl/rr_pkg.sv
package rr_pkg;
  localparam int RR_COPIES = 8;
  localparam int RR_BW     = 8;
  localparam int RR_SLOTS  = 2 * RR_COPIES;
  localparam int RR_HDR    = 2 * RR_COPIES;
  localparam int RR_SLOT_W = $clog2(RR_SLOTS);

  typedef enum logic [2:0] {
    ST_IDLE, ST_GATHER, ST_DRAIN, ST_EVAL, ST_FIN, ST_FAIL
  } rr_state_e;

  typedef enum logic { PH_HDR, PH_ENT } rr_phase_e;

  // number of copies equal to the copy at position cand
  function automatic int unsigned rr_match_count(
    input logic [RR_COPIES*RR_BW-1:0] v, input int unsigned cand);
    int unsigned n;
    logic [RR_BW-1:0] pick;
    n = 0;
    pick = v[cand*RR_BW +: RR_BW];
    for (int j = 0; j < RR_COPIES; j++)
      if (v[j*RR_BW +: RR_BW] == pick) n++;
    return n;
  endfunction

  // start of the copy selected by slot: low bits = copy, top bit = complemented set
  function automatic int unsigned rr_copy_base(
    input logic [RR_SLOT_W-1:0] slot, input int unsigned setsize);
    int unsigned copy_n;
    int unsigned inv;
    copy_n = int'(slot[RR_SLOT_W-2:0]);
    inv    = int'(slot[RR_SLOT_W-1]);
    return RR_HDR + (2 * copy_n + inv) * setsize;
  endfunction

  function automatic logic rr_count_ok(input logic [RR_BW-1:0] val, input int unsigned lim);
    return (val != '0) && (int'(val) <= lim);
  endfunction
endpackage

// File: rtl/rr_vote8.sv
module rr_vote8
  import rr_pkg::*;
(
  input  logic [RR_COPIES*RR_BW-1:0] copies,
  output logic [RR_BW-1:0]           value,
  output logic                       ok
);
  localparam int NCAND = RR_COPIES / 2;

  logic [NCAND-1:0] hit;

  for (genvar i = 0; i < NCAND; i++) begin : g_cand
    assign hit[i] = rr_match_count(copies, i) > NCAND;
  end

  always_comb begin
    value = '0;
    ok    = 1'b0;
    for (int i = NCAND - 1; i >= 0; i--) begin
      if (hit[i]) begin
        value = copies[i*RR_BW +: RR_BW];
        ok    = 1'b1;
      end
    end
  end
endmodule

// File: rtl/rr_addr_gen.sv
module rr_addr_gen
  import rr_pkg::*;
#(
  parameter int BUF_AW = 11,
  parameter int IDX_W  = 6,
  parameter int SZ_W   = 7
) (
  input  rr_phase_e             phase,
  input  logic [RR_SLOT_W-1:0]  slot,
  input  logic [IDX_W-1:0]      idx,
  input  logic [SZ_W-1:0]       setsize,
  output logic [BUF_AW-1:0]     addr
);
  int unsigned ent_off;

  always_comb begin
    ent_off = rr_copy_base(slot, int'(setsize)) + int'(idx);
    if (phase == PH_HDR) addr = BUF_AW'(slot);
    else                 addr = BUF_AW'(ent_off);
  end
endmodule

// File: rtl/rr_table_extract.sv
module rr_table_extract
  import rr_pkg::*;
#(
  parameter int MAX_MODES = 8,
  parameter int MAX_REGS  = 8,
  localparam int ENTRIES  = MAX_MODES * MAX_REGS,
  localparam int IDX_W    = (ENTRIES > 1) ? $clog2(ENTRIES) : 1,
  localparam int SZ_W     = $clog2(ENTRIES + 1),
  localparam int BUF_AW   = $clog2(RR_HDR + RR_SLOTS * ENTRIES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  output logic              rd_en,
  output logic [BUF_AW-1:0] rd_addr,
  input  logic [RR_BW-1:0]  rd_data,
  output logic [RR_BW-1:0]  mode_count,
  output logic [RR_BW-1:0]  reg_count,
  output logic              tbl_we,
  output logic [IDX_W-1:0]  tbl_addr,
  output logic [RR_BW-1:0]  tbl_wdata,
  output logic              busy,
  output logic              done,
  output logic              error
);
  localparam int HALF = RR_COPIES * RR_BW;

  rr_state_e              state_q;
  rr_phase_e              phase_q;
  logic [RR_SLOT_W-1:0]   slot_q, cap_slot_q;
  logic                   cap_en_q;
  logic [IDX_W-1:0]       idx_q;
  logic [SZ_W-1:0]        setsize_q;
  logic [RR_SLOTS*RR_BW-1:0] copies_q;
  logic [RR_BW-1:0]       modes_q, regs_q;
  logic                   we_q;
  logic [IDX_W-1:0]       waddr_q;
  logic [RR_BW-1:0]       wdata_q;

  logic [RR_BW-1:0] val_lo, val_hi;
  logic             ok_lo, ok_hi;
  logic [15:0]      prod;

  // named events for the checker
  logic ev_launch, ev_eval, ev_hdr_ok, ev_ent_ok, ev_fail, ev_last;

  rr_vote8 u_vote_lo (.copies(copies_q[HALF-1:0]),      .value(val_lo), .ok(ok_lo));
  rr_vote8 u_vote_hi (.copies(copies_q[2*HALF-1:HALF]), .value(val_hi), .ok(ok_hi));

  rr_addr_gen #(.BUF_AW(BUF_AW), .IDX_W(IDX_W), .SZ_W(SZ_W)) u_addr (
    .phase(phase_q), .slot(slot_q), .idx(idx_q), .setsize(setsize_q), .addr(rd_addr)
  );

  assign busy  = (state_q == ST_GATHER) || (state_q == ST_DRAIN) || (state_q == ST_EVAL);
  assign done  = (state_q == ST_FIN);
  assign error = (state_q == ST_FAIL);
  assign rd_en = (state_q == ST_GATHER);

  assign prod      = 16'(val_lo) * 16'(val_hi);
  assign ev_launch = start && !busy;
  assign ev_eval   = (state_q == ST_EVAL);
  assign ev_hdr_ok = ev_eval && (phase_q == PH_HDR) && ok_lo && ok_hi &&
                     rr_count_ok(val_lo, MAX_MODES) && rr_count_ok(val_hi, MAX_REGS);
  assign ev_ent_ok = ev_eval && (phase_q == PH_ENT) && ok_lo && ok_hi &&
                     ((val_lo ^ val_hi) == {RR_BW{1'b1}});
  assign ev_fail   = ev_eval && !ev_hdr_ok && !ev_ent_ok;
  assign ev_last   = (SZ_W'(idx_q) + SZ_W'(1)) == setsize_q;

  // capture pipeline: buffer answers one cycle after the request
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cap_en_q   <= 1'b0;
      cap_slot_q <= '0;
      copies_q   <= '0;
    end else begin
      cap_en_q   <= rd_en;
      cap_slot_q <= slot_q;
      if (cap_en_q) copies_q[cap_slot_q*RR_BW +: RR_BW] <= rd_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      phase_q   <= PH_HDR;
      slot_q    <= '0;
      idx_q     <= '0;
      setsize_q <= '0;
      modes_q   <= '0;
      regs_q    <= '0;
      we_q      <= 1'b0;
      waddr_q   <= '0;
      wdata_q   <= '0;
    end else begin
      we_q <= 1'b0;
      unique case (state_q)
        ST_IDLE, ST_FIN, ST_FAIL: begin
          if (start) begin
            state_q   <= ST_GATHER;
            phase_q   <= PH_HDR;
            slot_q    <= '0;
            idx_q     <= '0;
            setsize_q <= '0;
            modes_q   <= '0;
            regs_q    <= '0;
          end
        end
        ST_GATHER: begin
          slot_q <= slot_q + 1'b1;
          if (slot_q == RR_SLOT_W'(RR_SLOTS - 1)) state_q <= ST_DRAIN;
        end
        ST_DRAIN: state_q <= ST_EVAL;
        ST_EVAL: begin
          slot_q <= '0;
          if (ev_hdr_ok) begin
            modes_q   <= val_lo;
            regs_q    <= val_hi;
            setsize_q <= SZ_W'(prod);
            phase_q   <= PH_ENT;
            idx_q     <= '0;
            state_q   <= ST_GATHER;
          end else if (ev_ent_ok) begin
            we_q    <= 1'b1;
            waddr_q <= idx_q;
            wdata_q <= val_lo;
            if (ev_last) state_q <= ST_FIN;
            else begin
              idx_q   <= idx_q + 1'b1;
              state_q <= ST_GATHER;
            end
          end else begin
            state_q <= ST_FAIL;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign mode_count = modes_q;
  assign reg_count  = regs_q;
  assign tbl_we     = we_q;
  assign tbl_addr   = waddr_q;
  assign tbl_wdata  = wdata_q;
endmodule

// File: rtl/rr_table_extract_chk.sv
module rr_table_extract_chk #(
  parameter int MAX_MODES = 8,
  parameter int MAX_REGS  = 8,
  parameter int IDX_W     = 6,
  parameter int BUF_AW    = 11
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start,
  input logic              busy,
  input logic              done,
  input logic              error,
  input logic              rd_en,
  input logic [BUF_AW-1:0] rd_addr,
  input logic              tbl_we,
  input logic [IDX_W-1:0]  tbl_addr,
  input logic [7:0]        mode_count,
  input logic [7:0]        reg_count,
  input logic              ev_fail
);
  logic [IDX_W:0] wr_seen;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) wr_seen <= '0;
    else if (start && !busy) wr_seen <= '0;
    else if (tbl_we) wr_seen <= wr_seen + 1'b1;
  end

  assert_done_error_excl_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && error));

  assert_run_resolves_R9: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> (busy || done || error));

  assert_launch_from_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> ($past(start) && !$past(busy)));

  assert_read_while_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |-> busy);

  assert_read_in_page_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && mode_count != 0) |->
      (int'(rd_addr) < 16 + 16 * int'(mode_count) * int'(reg_count)));

  assert_write_order_R6: assert property (@(posedge clk) disable iff (!rst_n)
    tbl_we |-> (IDX_W'(wr_seen) == tbl_addr));

  assert_write_in_table_R3: assert property (@(posedge clk) disable iff (!rst_n)
    tbl_we |-> (int'(tbl_addr) < int'(mode_count) * int'(reg_count)));

  assert_counts_in_range_R1: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (mode_count != 0 && int'(mode_count) <= MAX_MODES &&
              reg_count != 0 && int'(reg_count) <= MAX_REGS));

  assert_fail_no_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ev_fail |=> (error && !tbl_we));
endmodule

bind rr_table_extract rr_table_extract_chk #(
  .MAX_MODES(MAX_MODES), .MAX_REGS(MAX_REGS), .IDX_W(IDX_W), .BUF_AW(BUF_AW)
) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done), .error(error),
  .rd_en(rd_en), .rd_addr(rd_addr), .tbl_we(tbl_we), .tbl_addr(tbl_addr),
  .mode_count(mode_count), .reg_count(reg_count), .ev_fail(ev_fail)
);

// File: tb/rr_table_extract_bench.sv
`timescale 1ns/1ps
module rr_table_extract_bench;
  localparam int BUF_AW = 11;
  localparam int IDX_W  = 6;
  localparam int MEMSZ  = 1 << BUF_AW;

  localparam logic [3:0] K_CLEAN = 4'd0, K_NRM3 = 4'd1, K_TIE = 4'd2, K_XOR = 4'd3,
                         K_HDR3 = 4'd4, K_HDRTIE = 4'd5, K_INVMAJ = 4'd6;

  typedef struct packed {
    logic [7:0] modes;
    logic [7:0] regs;
    logic [3:0] kind;
    logic [7:0] target;
  } vec_t;

  localparam int NVEC = 12;
  localparam vec_t VECS [NVEC] = '{
    '{8'd3, 8'd4, K_CLEAN,  8'd0},
    '{8'd8, 8'd8, K_CLEAN,  8'd0},
    '{8'd1, 8'd1, K_CLEAN,  8'd0},
    '{8'd5, 8'd3, K_NRM3,   8'd7},
    '{8'd4, 8'd4, K_TIE,    8'd6},
    '{8'd6, 8'd2, K_XOR,    8'd0},
    '{8'd2, 8'd7, K_HDR3,   8'd0},
    '{8'd3, 8'd3, K_HDRTIE, 8'd0},
    '{8'd0, 8'd4, K_CLEAN,  8'd0},
    '{8'd4, 8'd9, K_CLEAN,  8'd0},
    '{8'd9, 8'd8, K_CLEAN,  8'd0},
    '{8'd7, 8'd5, K_INVMAJ, 8'd20}
  };

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic rd_en, tbl_we, busy, done, error;
  logic [BUF_AW-1:0] rd_addr;
  logic [7:0] rd_data, mode_count, reg_count, tbl_wdata;
  logic [IDX_W-1:0] tbl_addr;

  logic [7:0] mem [MEMSZ];
  int wr_cnt, bad_wr, max_rd, cyc;
  int n_checks = 0, n_fail = 0;

  always #2.5 clk = ~clk;

  rr_table_extract u_rr_table_extract (
    .clk(clk), .rst_n(rst_n), .start(start), .rd_en(rd_en), .rd_addr(rd_addr),
    .rd_data(rd_data), .mode_count(mode_count), .reg_count(reg_count),
    .tbl_we(tbl_we), .tbl_addr(tbl_addr), .tbl_wdata(tbl_wdata),
    .busy(busy), .done(done), .error(error)
  );

  // buffer: registered read, one cycle latency
  always @(posedge clk) if (rd_en) rd_data <= mem[rd_addr];

  function automatic logic [7:0] exp_val(int e, int seed);
    return 8'((e * 29 + seed * 71 + 19) & 255);
  endfunction

  logic [7:0] cur_modes, cur_regs;
  int cur_seed;

  // write and read monitor
  always @(posedge clk) begin
    if (tbl_we) begin
      if (int'(tbl_addr) != wr_cnt || tbl_wdata != exp_val(wr_cnt, cur_seed)) bad_wr++;
      wr_cnt++;
    end
    if (rd_en && int'(rd_addr) > max_rd) max_rd = int'(rd_addr);
  end

  task automatic check(bit cond, string tag, int act, int exp);
    n_checks++;
    if (!cond) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
      summary();
    end
  end

  task automatic load_image(vec_t v, int seed);
    int s;
    logic [7:0] val;
    s = int'(v.modes) * int'(v.regs);
    for (int a = 0; a < MEMSZ; a++) mem[a] = 8'h00;
    for (int k = 0; k < 8; k++) begin
      mem[k]     = v.modes;
      mem[8 + k] = v.regs;
    end
    if (v.kind == K_HDR3) for (int k = 5; k < 8; k++) mem[k] = 8'h77;
    if (v.kind == K_HDRTIE) for (int k = 0; k < 4; k++) mem[8 + k] = v.regs + 8'd1;
    if (v.modes != 0 && v.regs != 0 && v.modes <= 8 && v.regs <= 8) begin
      for (int e = 0; e < s; e++) begin
        val = exp_val(e, seed);
        for (int k = 0; k < 8; k++) begin
          mem[16 + 2 * k * s + e]       = val;
          mem[16 + (2 * k + 1) * s + e] = ~val;
        end
      end
      val = exp_val(int'(v.target), seed);
      case (v.kind)
        K_NRM3: begin
          mem[16 + 0 * s + v.target] = val ^ 8'h01;
          mem[16 + 2 * s + v.target] = val ^ 8'h02;
          mem[16 + 4 * s + v.target] = val ^ 8'h04;
        end
        K_TIE: for (int k = 0; k < 4; k++) mem[16 + 2 * k * s + v.target] = val ^ 8'h5A;
        K_XOR: for (int k = 0; k < 8; k++) mem[16 + (2 * k + 1) * s + v.target] = ~val ^ 8'h01;
        K_INVMAJ: for (int k = 1; k < 8; k += 2) if (k != 7)
                    mem[16 + (2 * k + 1) * s + v.target] = 8'hC3;
        default: ;
      endcase
    end
  endtask

  task automatic pulse_start();
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
  endtask

  task automatic wait_end(output bit timed_out);
    int n = 0;
    timed_out = 0;
    while (!(done || error)) begin
      @(negedge clk);
      n++;
      if (n > 5000) begin timed_out = 1; break; end
    end
    repeat (2) @(negedge clk);
  endtask

  task automatic run_vec(int i, bit extra_start);
    vec_t v;
    bit range_bad, ent_bad, exp_err, to;
    int s, exp_wr;
    v = VECS[i];
    s = int'(v.modes) * int'(v.regs);
    range_bad = (v.modes == 0) || (v.regs == 0) || (v.modes > 8) || (v.regs > 8);
    ent_bad = (v.kind == K_TIE) || (v.kind == K_XOR);
    exp_err = range_bad || ent_bad || (v.kind == K_HDRTIE);
    exp_wr = exp_err ? (ent_bad && !range_bad ? int'(v.target) : 0) : s;
    cur_seed = i;
    load_image(v, i);
    wr_cnt = 0; bad_wr = 0; max_rd = 0;
    pulse_start();
    if (extra_start) begin
      repeat (10) @(negedge clk);
      pulse_start();
      repeat (300) @(negedge clk);
      pulse_start();
    end
    wait_end(to);
    check(!to, "R9 run ends", int'(to), 0);
    check(error == exp_err, exp_err ? "R2/R3/R5 error raised" : "R2 no error", int'(error), int'(exp_err));
    check(done == !exp_err, "R9 done flag", int'(done), int'(!exp_err));
    check(wr_cnt == exp_wr, extra_start ? "R7 write count" : "R6 write count", wr_cnt, exp_wr);
    check(bad_wr == 0, "R6 write addr/data", bad_wr, 0);
    if (!exp_err) begin
      check(mode_count == v.modes, "R1 mode count", int'(mode_count), int'(v.modes));
      check(reg_count == v.regs, "R1 reg count", int'(reg_count), int'(v.regs));
      check(max_rd == 16 + 16 * s - 1, "R4 read extent", max_rd, 16 + 16 * s - 1);
    end
  endtask

  initial begin
    bit to;
    wr_cnt = 0; bad_wr = 0; max_rd = 0; cyc = 0; cur_seed = 0;
    cur_modes = 0; cur_regs = 0;
    for (int a = 0; a < MEMSZ; a++) mem[a] = 8'h00;
    repeat (3) @(negedge clk);
    check(!busy && !done && !error && !tbl_we && !rd_en, "R8 reset outputs",
          int'({busy, done, error, tbl_we, rd_en}), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check(!busy && !rd_en, "R8 idle after reset", int'({busy, rd_en}), 0);

    for (int i = 0; i < NVEC; i++) run_vec(i, 1'b0);

    // R7: extra start pulses during a full-size run
    run_vec(1, 1'b1);

    // R9: done holds, then a new start clears it
    repeat (20) @(negedge clk);
    check(done && !error, "R9 done held", int'(done), 1);
    load_image(VECS[7], 7);
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    check(!done && !error && busy, "R9 start clears done", int'({done, error, busy}), 1);
    wait_end(to);
    check(error && !done, "R9 error after header tie", int'(error), 1);
    repeat (20) @(negedge clk);
    check(error, "R9 error held", int'(error), 1);
    check(mode_count == 0 && reg_count == 0, "R3 counts not reported on error",
          int'(mode_count) + int'(reg_count), 0);
    load_image(VECS[0], 0);
    cur_seed = 0; wr_cnt = 0; bad_wr = 0;
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    check(!error && busy, "R9 start clears error", int'(error), 0);
    wait_end(to);
    check(done && wr_cnt == 12 && bad_wr == 0, "R6 rerun after error", wr_cnt, 12);
    summary();
  end
endmodule